// File: doc/BRIEF.md
# Tunable Quadrature Downconverter with Power-of-Two Decimation

This block takes a stream of signed 16-bit real samples, one per clock when `in_valid` is high, and turns it into a lower-rate stream. In complex mode, a numerically controlled oscillator drives a quadrature mixer. The mixer shifts the band of interest down to zero frequency, and a four-stage cascaded integrator-comb (CIC) low-pass decimator then produces an I/Q pair. In real mode the oscillator is parked and the mixer is bypassed, so the same CIC acts as a plain low-pass decimator with one real output stream.

The decimation exponent `dec_exp` selects the complex ratio N = 2^e. Real mode halves the ratio, which doubles the output rate for the same setting. `wide_mode` picks the output format. In narrow format each sample is rounded to 16 bits and sign-extended on the 32-bit ports. In wide format the port carries a 32-bit value with 16 fraction bits, for high ratios where 16-bit rounding would set the noise floor. A change of ratio or mode flushes the filter and holds `out_valid` low until the chain has refilled. A change of tuning word does not disturb the oscillator phase.

Top module: `ddc_top`

## Requirements
- R1: The oscillator phase is a 48-bit accumulator. It starts at zero after reset and adds `tune_word` once per accepted complex-mode sample. A change of `tune_word` never resets it, so the phase is carried across retunes.
- R2: In complex mode the decimation ratio is N = 2^e, with e taken from `dec_exp` in 2..7. Values below 2 act as 2. With continuous input, `out_valid` pulses once every N clocks.
- R3: The mixer computes I = x·C(p) and Q = −x·S(p). S and C come from a quarter-wave table of 257 entries addressed by the top 10 phase bits, with peak value 32767. At phase 0, C = 32767 and S = 0. At the quarter-turn phase 2^46, C = 0 and S = 32767. At the half-turn phase 2^47, C = −32767 and S = 0.
- R4: The mixed value carries 16 fraction bits on the same scale as a bypassed sample (x·65536). The mixer therefore halves the signal: a DC input x at zero tuning settles to I = x·32767/65536 and Q = 0.
- R5: In real mode the mixer is bypassed and the phase accumulator is held whatever `tune_word` holds. A DC input x settles to `out_i` = x (narrow). `out_q` stays 0 on every output pulse.
- R6: In real mode the ratio is N/2 = 2^(e−1), so `out_valid` pulses once every N/2 clocks with continuous input.
- R7: In narrow format the CIC result is rounded half-up to an integer, saturated to −32768..32767, and sign-extended to 32 bits. For example, −16383.5 becomes −16383 and 0.99997 becomes 1.
- R8: In wide format the port carries the rounded result with 16 fraction bits, saturated to the 32-bit range. For example, complex x = 1000 gives 32767000, and real x = 32767 gives 2147418112.
- R9: A change of the effective exponent or of the mode clears the filter. No `out_valid` pulse appears until more than 6·R further samples have been accepted, where R is the new ratio.
- R10: While reset is high and right after it, `out_valid`, `out_i` and `out_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| tune_word | input | 48 | Oscillator phase step per sample |
| real_mode | input | 1 | 1: real low-pass mode, 0: complex mode |
| dec_exp | input | 3 | Decimation exponent e (complex ratio 2^e) |
| wide_mode | input | 1 | 1: 32-bit output with 16 fraction bits, 0: rounded 16-bit |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 32 | In-phase output, or the real output in real mode |
| out_q | output | 32 | Quadrature output, 0 in real mode |

## Verification
A phase accumulator that loses its value on a retune shows up within a few output periods. After a one-sample quarter-turn advance, a DC input should settle to I = 0 and Q = −500, but a cleared phase gives I = 500 and Q = 0 instead. The same holds across a real-mode interval. A stale integrator or a wrong comb delay leaves a residue in the DC-settled values, or breaks the exact zero that the half-turn tuning word must produce. A decimation counter or flush fault shows up directly in the clock spacing of `out_valid` and in how long the output stays silent after a reconfiguration.

// File: rtl/ddc_pkg.sv
`timescale 1ns/1ps
package ddc_pkg;
  localparam int PHASE_BITS = 48;
  localparam int SAMPLE_BITS = 16;
  localparam int LUT_ADDR_BITS = 10;
  localparam int AMP_BITS = 16;
  localparam int MIX_BITS = 32;
  localparam int CIC_STAGES = 4;
  localparam int EXP_MAX = 7;
  localparam int EXP_MIN = 2;
  localparam int OUT_BITS = 32;
  localparam int SETTLE_OUTS = 6;
endpackage

// File: rtl/ddc_nco.sv
`timescale 1ns/1ps
module ddc_nco #(
  parameter int PHASE_W = ddc_pkg::PHASE_BITS,
  parameter int ADDR_W  = ddc_pkg::LUT_ADDR_BITS,
  parameter int AMP_W   = ddc_pkg::AMP_BITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     hold,
  input  logic [PHASE_W-1:0]       step,
  output logic signed [AMP_W-1:0]  cos_o,
  output logic signed [AMP_W-1:0]  sin_o
);
  localparam int QTR   = 1 << (ADDR_W - 2);
  localparam int IDX_W = ADDR_W - 1;

  logic signed [AMP_W-1:0] rom [0:QTR];
  logic [PHASE_W-1:0]      acc;
  logic [ADDR_W-1:0]       ph_top;

  initial begin
    for (int i = 0; i <= QTR; i++)
      rom[i] = AMP_W'($rtoi(real'((1 << (AMP_W - 1)) - 1) *
               $sin(real'(i) * 3.14159265358979 / real'(2 * QTR)) + 0.5));
  end

  function automatic logic signed [AMP_W-1:0] wave(input logic [ADDR_W-1:0] p);
    logic [IDX_W-1:0] a;
    a = p[ADDR_W-2] ? IDX_W'(QTR) - {1'b0, p[ADDR_W-3:0]} : {1'b0, p[ADDR_W-3:0]};
    return p[ADDR_W-1] ? -rom[a] : rom[a];
  endfunction

  assign ph_top = acc[PHASE_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      sin_o <= wave(ph_top);
      cos_o <= wave(ph_top + ADDR_W'(QTR));
      if (in_valid && !hold) acc <= acc + step;
    end
  end

  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (rst)
    (hold || !in_valid) |=> $stable(acc)); // R5
endmodule

// File: rtl/ddc_mixer.sv
`timescale 1ns/1ps
module ddc_mixer #(
  parameter int SAMP_W = ddc_pkg::SAMPLE_BITS,
  parameter int AMP_W  = ddc_pkg::AMP_BITS,
  parameter int MIX_W  = ddc_pkg::MIX_BITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     bypass,
  input  logic signed [SAMP_W-1:0] x,
  input  logic signed [AMP_W-1:0]  cos_i,
  input  logic signed [AMP_W-1:0]  sin_i,
  output logic                     out_valid,
  output logic signed [MIX_W-1:0]  mix_i,
  output logic signed [MIX_W-1:0]  mix_q
);
  localparam int FRAC = MIX_W - SAMP_W;

  logic signed [MIX_W-1:0] prod_i, prod_q, pass_i;

  assign prod_i = MIX_W'(x) * MIX_W'(cos_i);
  assign prod_q = MIX_W'(x) * MIX_W'(sin_i);
  assign pass_i = MIX_W'(x) <<< FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mix_i     <= '0;
      mix_q     <= '0;
    end else begin
      out_valid <= in_valid;
      mix_i     <= bypass ? pass_i : prod_i;
      mix_q     <= bypass ? '0 : -prod_q;
    end
  end
endmodule

// File: rtl/ddc_cic.sv
`timescale 1ns/1ps
module ddc_cic #(
  parameter int IN_W     = ddc_pkg::MIX_BITS,
  parameter int STAGES   = ddc_pkg::CIC_STAGES,
  parameter int MAX_EXP  = ddc_pkg::EXP_MAX,
  parameter int OUT_W    = ddc_pkg::OUT_BITS,
  parameter int NARROW_W = ddc_pkg::SAMPLE_BITS,
  parameter int SETTLE   = ddc_pkg::SETTLE_OUTS,
  localparam int K_W     = $clog2(MAX_EXP + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [K_W-1:0]          k,
  input  logic                    wide,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data
);
  localparam int ACC_W = IN_W + STAGES * MAX_EXP;
  localparam int SH_W  = $clog2(STAGES * MAX_EXP + OUT_W + 1);
  localparam int SUP_W = $clog2(SETTLE + 1);
  localparam int FRAC  = OUT_W - NARROW_W;

  logic signed [ACC_W-1:0] integ [STAGES];
  logic signed [ACC_W-1:0] dly   [STAGES];
  logic signed [ACC_W-1:0] d     [STAGES+1];
  logic [MAX_EXP-1:0]      cnt;
  logic [MAX_EXP:0]        ratio;
  logic [SUP_W-1:0]        sup;
  logic                    strobe;
  logic [SH_W-1:0]         sh;
  logic signed [ACC_W:0]   ext, half, shifted, lim_hi, lim_lo, sat;

  assign ratio  = (MAX_EXP + 1)'(1) << k;
  assign strobe = in_valid && ({1'b0, cnt} == ratio - (MAX_EXP + 1)'(1));
  assign sh     = SH_W'(STAGES) * SH_W'(k) + (wide ? SH_W'(0) : SH_W'(FRAC));

  always_comb begin
    d[0] = integ[STAGES-1];
    for (int j = 0; j < STAGES; j++) d[j+1] = d[j] - dly[j];
    ext     = (ACC_W + 1)'(d[STAGES]);
    half    = (ACC_W + 1)'(1) <<< (sh - SH_W'(1));
    shifted = (ext + half) >>> sh;
    lim_hi  = ((ACC_W + 1)'(1) <<< (wide ? OUT_W - 1 : NARROW_W - 1)) - (ACC_W + 1)'(1);
    lim_lo  = -lim_hi - (ACC_W + 1)'(1);
    if (shifted > lim_hi)      sat = lim_hi;
    else if (shifted < lim_lo) sat = lim_lo;
    else                       sat = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int j = 0; j < STAGES; j++) begin
        integ[j] <= '0;
        dly[j]   <= '0;
      end
      cnt       <= '0;
      sup       <= SUP_W'(SETTLE);
      out_valid <= 1'b0;
      if (rst) out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        integ[0] <= integ[0] + ACC_W'(in_data);
        for (int j = 1; j < STAGES; j++) integ[j] <= integ[j] + integ[j-1];
        cnt <= strobe ? '0 : cnt + 1'b1;
        if (strobe) begin
          for (int j = 0; j < STAGES; j++) dly[j] <= d[j];
          if (sup != '0) sup <= sup - 1'b1;
          else begin
            out_valid <= 1'b1;
            out_data  <= OUT_W'(sat);
          end
        end
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid); // R9
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(wide)) |->
      ($signed(out_data) <= 32767 && $signed(out_data) >= -32768)); // R7
endmodule

// File: rtl/ddc_top.sv
`timescale 1ns/1ps
module ddc_top
  import ddc_pkg::*;
#(
  parameter int PHASE_W = PHASE_BITS,
  parameter int SAMP_W  = SAMPLE_BITS,
  parameter int AMP_W   = AMP_BITS,
  parameter int ADDR_W  = LUT_ADDR_BITS,
  parameter int MIX_W   = MIX_BITS,
  parameter int STAGES  = CIC_STAGES,
  parameter int MIN_EXP = EXP_MIN,
  parameter int MAX_EXP = EXP_MAX,
  parameter int OUT_W   = OUT_BITS,
  parameter int SETTLE  = SETTLE_OUTS,
  localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [SAMP_W-1:0]  in_data,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic               real_mode,
  input  logic [EXP_W-1:0]   dec_exp,
  input  logic               wide_mode,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_i,
  output logic [OUT_W-1:0]   out_q
);
  logic signed [SAMP_W-1:0] x_a;
  logic                     v_a, byp_a;
  logic signed [AMP_W-1:0]  cos_w, sin_w;
  logic                     v_m;
  logic signed [MIX_W-1:0]  lane_in  [2];
  logic                     lane_v   [2];
  logic [OUT_W-1:0]         lane_out [2];
  logic [EXP_W-1:0]         eff_exp, k;
  logic [EXP_W:0]           cfg_prev;
  logic                     flush;

  assign eff_exp = (dec_exp < EXP_W'(MIN_EXP)) ? EXP_W'(MIN_EXP) : dec_exp;
  assign k       = real_mode ? eff_exp - 1'b1 : eff_exp;
  assign flush   = ({real_mode, k} != cfg_prev);

  always_ff @(posedge clk) begin
    cfg_prev <= {real_mode, k};
    if (rst) begin
      x_a   <= '0;
      v_a   <= 1'b0;
      byp_a <= 1'b0;
    end else begin
      x_a   <= $signed(in_data);
      v_a   <= in_valid;
      byp_a <= real_mode;
    end
  end

  ddc_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_nco (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hold(real_mode),
    .step(tune_word), .cos_o(cos_w), .sin_o(sin_w));

  ddc_mixer #(.SAMP_W(SAMP_W), .AMP_W(AMP_W), .MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst(rst), .in_valid(v_a), .bypass(byp_a), .x(x_a),
    .cos_i(cos_w), .sin_i(sin_w), .out_valid(v_m),
    .mix_i(lane_in[0]), .mix_q(lane_in[1]));

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    ddc_cic #(.IN_W(MIX_W), .STAGES(STAGES), .MAX_EXP(MAX_EXP), .OUT_W(OUT_W),
              .NARROW_W(SAMP_W), .SETTLE(SETTLE)) u_cic (
      .clk(clk), .rst(rst), .flush(flush && !rst), .in_valid(v_m),
      .in_data(lane_in[ln]), .k(k), .wide(wide_mode),
      .out_valid(lane_v[ln]), .out_data(lane_out[ln]));
  end

  assign out_valid = lane_v[0] & lane_v[1];
  assign out_i     = lane_out[0];
  assign out_q     = lane_out[1];

  AST_REAL_Q_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && real_mode && $past(real_mode)) |-> (out_q == '0)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0)); // R10
endmodule

// File: tb/sim_ddc_top.sv
`timescale 1ns/1ps
module sim_ddc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_data;
  logic [47:0] tune_word;
  logic        real_mode;
  logic [2:0]  dec_exp;
  logic        wide_mode;
  logic        out_valid;
  logic [31:0] out_i, out_q;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  ddc_top u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tune_word(tune_word), .real_mode(real_mode), .dec_exp(dec_exp),
    .wide_mode(wide_mode), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  typedef struct packed {
    logic        rm;
    logic [2:0]  e;
    logic        w;
    logic [15:0] x;
    logic [47:0] ftw;
    logic [31:0] ei;
    logic [31:0] eq;
  } vec_t;

  // DC settled values: complex I = round_half_up(x*32767/65536), real I = x
  localparam vec_t VECS [8] = '{
    '{1'b0, 3'd2, 1'b0, 16'sd1000,   48'd0,       32'sd500,        32'sd0},
    '{1'b0, 3'd3, 1'b0, -16'sd32768, 48'd0,       -32'sd16383,     32'sd0},
    '{1'b0, 3'd5, 1'b1, 16'sd1000,   48'd0,       32'sd32767000,   32'sd0},
    '{1'b1, 3'd3, 1'b0, -16'sd1234,  48'd0,       -32'sd1234,      32'sd0},
    '{1'b1, 3'd7, 1'b1, 16'sd32767,  48'd0,       32'sd2147418112, 32'sd0},
    '{1'b0, 3'd4, 1'b0, 16'sd2,      48'd0,       32'sd1,          32'sd0},
    '{1'b0, 3'd6, 1'b0, 16'sd1,      48'd0,       32'sd0,          32'sd0},
    '{1'b0, 3'd2, 1'b0, 16'sd20000,  48'h8000_0000_0000, 32'sd0,   32'sd0}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    nchk++;
    if (act != exp_v) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_out(input string req, input int n, input int limit, output int cyc);
    int got = 0;
    cyc = 0;
    while (got < n && cyc < limit) begin
      tick();
      cyc++;
      if (out_valid) got++;
    end
    if (got < n) begin
      nchk++;
      nfail++;
      $display("FAIL %s timeout actual=%0d expected=%0d outputs", req, got, n);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (4) tick();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int c;
    in_data = '0; tune_word = '0; real_mode = 1'b0; dec_exp = 3'd2; wide_mode = 1'b0;
    do_reset();

    // R10: quiet outputs after reset
    tick();
    chk("R10 out_valid", int'(out_valid), 0);
    chk("R10 out_i", $signed(out_i), 0);
    chk("R10 out_q", $signed(out_q), 0);

    // Table walk (phase stays 0 until the last row, which uses a half-turn step)
    for (int v = 0; v < 8; v++) begin
      real_mode = VECS[v].rm;
      dec_exp   = VECS[v].e;
      wide_mode = VECS[v].w;
      in_data   = VECS[v].x;
      tune_word = VECS[v].ftw;
      in_valid  = 1'b1;
      wait_out("R3/R4/R5/R7/R8", 3, 4000, c);
      chk($sformatf("R3 R4 R5 R7 R8 vec%0d I", v), $signed(out_i), $signed(VECS[v].ei));
      chk($sformatf("R3 R5 vec%0d Q", v), $signed(out_q), $signed(VECS[v].eq));
    end

    // R2: complex spacing, including exponent clamp
    real_mode = 1'b0; tune_word = '0; in_data = 16'sd100; wide_mode = 1'b0;
    dec_exp = 3'd3;
    wait_out("R2", 1, 4000, c);
    wait_out("R2", 1, 4000, c);
    chk("R2 spacing e=3", c, 8);
    dec_exp = 3'd0;
    wait_out("R2", 1, 4000, c);
    wait_out("R2", 1, 4000, c);
    chk("R2 spacing e=0 clamps to 4", c, 4);

    // R6: real mode halves the ratio
    real_mode = 1'b1; dec_exp = 3'd3;
    wait_out("R6", 1, 4000, c);
    wait_out("R6", 1, 4000, c);
    chk("R6 real spacing e=3", c, 4);

    // R9: flush silence after ratio change (new R = 16)
    real_mode = 1'b0; dec_exp = 3'd4;
    wait_out("R9", 1, 4000, c);
    chk("R9 silent beyond 6R", int'(c > 96), 1);
    chk("R9 first output bound", int'(c <= 7 * 16 + 2), 1);

    // R1: phase carried across a retune
    real_mode = 1'b0; dec_exp = 3'd2; in_data = 16'sd1000; tune_word = 48'h4000_0000_0000;
    do_reset();
    in_valid = 1'b1;
    tick();
    tune_word = '0;
    wait_out("R1", 8, 4000, c);
    chk("R1 I at quarter phase", $signed(out_i), 0);
    chk("R1 Q at quarter phase", $signed(out_q), -500);

    // R5: real mode ignores tuning and holds the phase
    real_mode = 1'b1; tune_word = 48'h4000_0000_0000;
    wait_out("R5", 8, 4000, c);
    chk("R5 real I", $signed(out_i), 1000);
    chk("R5 real Q", $signed(out_q), 0);
    real_mode = 1'b0; tune_word = '0;
    wait_out("R5", 8, 4000, c);
    chk("R5 phase held I", $signed(out_i), 0);
    chk("R5 phase held Q", $signed(out_q), -500);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule